// File: doc/BRIEF.md
# Processor Performance Monitor Counter Unit

This block sits next to a processor core and counts what the core reports. It has four 32-bit event counters. Each counter picks its event through a 3-bit selector in a shared control word. The events are core cycles, completed instructions, dispatched instructions (0 to 2 per cycle), prescaled time-base ticks, and latency events that exceed a programmable threshold. Counting can be frozen by a global bit, by privilege level, by a per-process mark input, or by an external mask pin. Counters 2 to 4 can be chained so that they wait until counter 1 turns negative.

When counter 2, 3 or 4 turns negative through counting, the unit can freeze every counter, raise an interrupt, or do both. The freeze stays set in the control word and the interrupt stays pending until software clears it. The external mask pin can block the interrupt instead of, or as well as, the counting. Software reaches the unit through a plain write port and a combinational read port. Every write is dropped while the core runs at user privilege. There is no data stream in this block, so no interface here carries valid/ready or back-pressure. All pins are plain control or status.

Top module: `perf_monitor`

## Requirements
- R1: Register addresses are 0 for control, 1 to 4 for counters 1 to 4, and 5 for status, where bit 0 is the pending interrupt. After reset every register and `irq` read 0.
- R1 (continued): The control word has the following fields.
  - bit 0: global freeze
  - bit 1: freeze while supervisor
  - bit 2: freeze while user
  - bit 3: freeze while marked
  - bit 4: chain enable
  - bit 5: overflow freezes
  - bit 6: overflow interrupts
  - bit 7: external mask blocks counting
  - bit 8: external mask blocks interrupt
  - bit 9: threshold scale (0 gives ×2, 1 gives ×32)
  - bits 15:10: threshold
  - bits 17:16: time-base divide select
  - bits 18+3i to 20+3i: event code of counter i+1
- R2: Event code 1 adds 1 on every cycle.
- R3: Event code 2 adds 1 in each cycle that `ev_complete` is high.
- R4: Event code 3 adds `ev_dispatch` each cycle, with the value 3 clamped to 2. No counter ever advances by more than 2 in one cycle.
- R5: Event code 4 adds 1 once every D ticks of `tb_tick`, where D is 32, 8192, 131072 or 2097152 for divide select 0 to 3. The prescaler is free-running from reset.
- R6: Event code 5 adds 1 in a cycle where `lat_valid` is high and `lat_cycles` is strictly greater than threshold×2 (scale 0) or threshold×32 (scale 1).
- R7: No counter moves while any of these freeze conditions holds:
  - global freeze is set;
  - supervisor freeze is set with `priv_user` low;
  - user freeze is set with `priv_user` high;
  - mark freeze is set with `proc_mark` high.
- R8: With chain enable set, counters 2 to 4 hold while bit 31 of counter 1 is 0. Once that bit is 1 they count normally.
- R9: When counter 2, 3 or 4 crosses bit 31 from 0 to 1 by counting, two things can happen:
  - with overflow-freeze set, global freeze becomes 1 and stays 1 until software writes it;
  - with overflow-interrupt set, the status bit is set.
  - Counter 1 crossing never does either.
- R10: With `ext_mask` high, counting stops if bit 7 is set and new interrupts are suppressed if bit 8 is set.
- R11: `irq` equals the pending status bit. It stays high until a write of 1 to status bit 0.
- R12: Writes with `priv_user` high change no register.
- R13: Event codes 0, 6 and 7 never advance a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| priv_user | input | 1 | High while core runs at user privilege |
| proc_mark | input | 1 | Mark bit of the running process |
| ext_mask | input | 1 | External mask pin |
| ev_complete | input | 1 | Instruction completed (folded branches excluded) |
| ev_dispatch | input | 2 | Instructions dispatched this cycle |
| tb_tick | input | 1 | Time-base tick strobe |
| lat_valid | input | 1 | A latency measurement is presented |
| lat_cycles | input | 12 | Latency of the presented event |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default parameters: four 32-bit counters, a 12-bit latency input and a 21-bit prescaler. The latency input is wide enough to reach the top ×32 threshold of 2016 and values just past it. The bench sweeps every event code and every threshold-scale combination at its boundary values. It also runs enough time-base ticks to cross an 8192-tick prescale boundary from a nonzero phase. Counters are preloaded near bit 31, so chaining, overflow freeze, interrupt-only and masked-interrupt cases each resolve within a few cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CTRL_W = 32;
  localparam int SEL_W  = 3;

  // control word bit positions
  localparam int B_FRZ       = 0;
  localparam int B_FRZ_SUP   = 1;
  localparam int B_FRZ_USR   = 2;
  localparam int B_FRZ_MARK  = 3;
  localparam int B_CHAIN     = 4;
  localparam int B_OVF_FRZ   = 5;
  localparam int B_OVF_IRQ   = 6;
  localparam int B_XM_CNT    = 7;
  localparam int B_XM_IRQ    = 8;
  localparam int B_THR_SCALE = 9;
  localparam int B_THR_LO    = 10;
  localparam int THR_W       = 6;
  localparam int B_TBDIV_LO  = 16;
  localparam int B_SEL_LO    = 18;

  localparam int THRV_W      = THR_W + 5;

  // time-base prescale shifts for divide selects 0..3
  localparam int TB_SH0 = 5;
  localparam int TB_SH1 = 13;
  localparam int TB_SH2 = 17;
  localparam int TB_SH3 = 21;

  typedef enum logic [SEL_W-1:0] {
    EV_NONE     = 3'd0,
    EV_CYCLE    = 3'd1,
    EV_COMPLETE = 3'd2,
    EV_DISPATCH = 3'd3,
    EV_TBASE    = 3'd4,
    EV_LATENCY  = 3'd5
  } ev_sel_e;

  function automatic logic [THRV_W-1:0] thr_value(input logic [THR_W-1:0] t, input logic coarse);
    return coarse ? {t, 5'b0} : {4'b0, t, 1'b0};
  endfunction
endpackage

// File: rtl/pmu_tb_prescale.sv
module pmu_tb_prescale #(
  parameter int PRE_W = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] div_sel,
  output logic       pulse
);
  import pmu_pkg::*;

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;
  int               sh;

  always_comb begin
    case (div_sel)
      2'd0:    sh = TB_SH0;
      2'd1:    sh = TB_SH1;
      2'd2:    sh = TB_SH2;
      default: sh = TB_SH3;
    endcase
    mask  = PRE_W'((64'd1 << sh) - 64'd1);
    pulse = tick && ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (tick) phase_q <= phase_q + PRE_W'(1);
  end
endmodule

// File: rtl/pmu_event_mux.sv
module pmu_event_mux #(
  parameter int LAT_W = 12
) (
  input  logic [pmu_pkg::SEL_W-1:0]  sel,
  input  logic                       ev_complete,
  input  logic [1:0]                 ev_dispatch,
  input  logic                       tb_pulse,
  input  logic                       lat_valid,
  input  logic [LAT_W-1:0]           lat_cycles,
  input  logic [pmu_pkg::THRV_W-1:0] thr_val,
  output logic [1:0]                 inc
);
  import pmu_pkg::*;

  localparam int CMP_W = (LAT_W > THRV_W) ? LAT_W : THRV_W;

  logic lat_hit;
  logic [1:0] disp_amt;

  always_comb begin
    lat_hit  = lat_valid && (CMP_W'(lat_cycles) > CMP_W'(thr_val));
    disp_amt = (ev_dispatch == 2'd3) ? 2'd2 : ev_dispatch;
    case (sel)
      EV_CYCLE:    inc = 2'd1;
      EV_COMPLETE: inc = {1'b0, ev_complete};
      EV_DISPATCH: inc = disp_amt;
      EV_TBASE:    inc = {1'b0, tb_pulse};
      EV_LATENCY:  inc = {1'b0, lat_hit};
      default:     inc = 2'd0;
    endcase
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  input  logic             run,
  input  logic [1:0]       inc,
  output logic [CTR_W-1:0] value,
  output logic             went_neg
);
  logic [CTR_W-1:0] sum;

  always_comb begin
    sum      = value + CTR_W'(inc);
    went_neg = run && !load && !value[CTR_W-1] && sum[CTR_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (run)  value <= sum;
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int LAT_W   = 12,
  parameter int PRE_W   = 21,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              priv_user,
  input  logic              proc_mark,
  input  logic              ext_mask,
  input  logic              ev_complete,
  input  logic [1:0]        ev_dispatch,
  input  logic              tb_tick,
  input  logic              lat_valid,
  input  logic [LAT_W-1:0]  lat_cycles,
  output logic              irq
);
  import pmu_pkg::*;

  localparam int A_CTRL = 0;
  localparam int A_CTR0 = 1;
  localparam int A_STAT = A_CTR0 + NUM_CTR;

  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q;
  logic [CTR_W-1:0]  cnt [NUM_CTR];
  logic [NUM_CTR-1:0] neg_evt;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic              wr_ok, base_run, tb_pulse, ovf_any, pend_set, pend_clr;
  logic [THRV_W-1:0] thr_val;

  assign wr_ok   = wr_en && !priv_user;
  assign thr_val = thr_value(ctrl_q[B_THR_LO +: THR_W], ctrl_q[B_THR_SCALE]);

  assign base_run = !ctrl_q[B_FRZ]
                 && !(ctrl_q[B_FRZ_SUP]  && !priv_user)
                 && !(ctrl_q[B_FRZ_USR]  &&  priv_user)
                 && !(ctrl_q[B_FRZ_MARK] &&  proc_mark)
                 && !(ctrl_q[B_XM_CNT]   &&  ext_mask);

  pmu_tb_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick),
    .div_sel(ctrl_q[B_TBDIV_LO +: 2]), .pulse(tb_pulse)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [1:0] inc;
    logic       run;
    logic       load;

    pmu_event_mux #(.LAT_W(LAT_W)) u_mux (
      .sel(ctrl_q[B_SEL_LO + SEL_W*i +: SEL_W]),
      .ev_complete(ev_complete), .ev_dispatch(ev_dispatch),
      .tb_pulse(tb_pulse), .lat_valid(lat_valid), .lat_cycles(lat_cycles),
      .thr_val(thr_val), .inc(inc)
    );

    if (i == 0) begin : g_head
      assign run = base_run;
    end else begin : g_tail
      assign run = base_run && (!ctrl_q[B_CHAIN] || cnt[0][CTR_W-1]);
    end

    assign load = wr_ok && (wr_addr == ADDR_W'(A_CTR0 + i));

    pmu_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CTR_W-1:0]),
      .run(run), .inc(inc), .value(cnt[i]), .went_neg(neg_evt[i])
    );

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
  end

  // only counters 2..N raise the overflow response
  assign ovf_any  = |neg_evt[NUM_CTR-1:1];
  assign pend_set = ovf_any && ctrl_q[B_OVF_IRQ] && !(ext_mask && ctrl_q[B_XM_IRQ]);
  assign pend_clr = wr_ok && (wr_addr == ADDR_W'(A_STAT)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ok && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data;
      if (ovf_any && ctrl_q[B_OVF_FRZ]) ctrl_q[B_FRZ] <= 1'b1;
      pend_q <= pend_set || (pend_q && !pend_clr);
    end
  end

  assign irq = pend_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = ctrl_q;
    if (rd_addr == ADDR_W'(A_STAT)) rd_data = {31'b0, pend_q};
    for (int k = 0; k < NUM_CTR; k++)
      if (rd_addr == ADDR_W'(A_CTR0 + k)) rd_data = 32'(cnt[k]);
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     clr_bit,
  input logic                     priv_user,
  input logic                     ext_mask,
  input logic                     irq,
  input logic [31:0]              ctrl_q,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  import pmu_pkg::*;

  localparam int A_STAT = 1 + NUM_CTR;

  logic sw_wr;
  assign sw_wr = wr_en && !priv_user;

  assert_irq_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(sw_wr && wr_addr == ADDR_W'(A_STAT) && clr_bit) |=> irq);

  assert_user_write_dropped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && priv_user |=> $stable(ctrl_q[31:1]));

  assert_frozen_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_FRZ] && !sw_wr |=> $stable(cnt_flat));

  assert_chain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_CHAIN] && !cnt_flat[CTR_W-1] && !sw_wr
      |=> $stable(cnt_flat[NUM_CTR*CTR_W-1:CTR_W]));

  assert_step_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (cnt_flat[CTR_W-1:0] - $past(cnt_flat[CTR_W-1:0])) <= CTR_W'(2));

  assert_ovf_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr && ctrl_q[B_OVF_FRZ] && !cnt_flat[2*CTR_W-1] ##1 cnt_flat[2*CTR_W-1]
      |-> ctrl_q[B_FRZ]);

  assert_mask_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mask && ctrl_q[B_XM_CNT] && !sw_wr |=> $stable(cnt_flat));
endmodule

bind perf_monitor pmu_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .clr_bit(wr_data[0]),
  .priv_user(priv_user), .ext_mask(ext_mask), .irq(irq),
  .ctrl_q(ctrl_q), .cnt_flat(cnt_flat)
);

// File: tb/tb_perf_monitor.sv
module tb_perf_monitor;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        priv_user = 0, proc_mark = 0, ext_mask = 0;
  logic        ev_complete = 0;
  logic [1:0]  ev_dispatch = 0;
  logic        tb_tick = 0, lat_valid = 0;
  logic [11:0] lat_cycles = 0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint tb_total = 0;

  localparam logic [31:0] F_FRZ = 32'h1, F_SUP = 32'h2, F_USR = 32'h4, F_MARK = 32'h8;
  localparam logic [31:0] F_CHAIN = 32'h10, F_OFRZ = 32'h20, F_OIRQ = 32'h40;
  localparam logic [31:0] F_XMC = 32'h80, F_XMI = 32'h100, F_SCALE = 32'h200;

  perf_monitor dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .priv_user(priv_user), .proc_mark(proc_mark),
    .ext_mask(ext_mask), .ev_complete(ev_complete), .ev_dispatch(ev_dispatch),
    .tb_tick(tb_tick), .lat_valid(lat_valid), .lat_cycles(lat_cycles), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] cfg(input int s0, s1, s2, s3, input logic [31:0] f);
    return f | (32'(s0) << 18) | (32'(s1) << 21) | (32'(s2) << 24) | (32'(s3) << 27);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = 3'(a); #1; v = rd_data;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] i0, i1, i2, i3);
    ext_mask = 0; priv_user = 0; proc_mark = 0;
    wr(0, 0); wr(5, 1);
    wr(1, i0); wr(2, i1); wr(3, i2); wr(4, i3);
    wr(0, c);
  endtask

  task automatic tb_run(input int sel, input int n, input int every);
    longint p0, d, e;
    p0 = tb_total;
    d = (sel == 0) ? 32 : 8192;
    setup(cfg(4, 4, 4, 4, F_XMC | (32'(sel) << 16)), 0, 0, 0, 0);
    for (int k = 0; k < n; k++) begin
      tb_tick = (k % every) == 0;
      if (tb_tick) tb_total++;
      step(1);
    end
    tb_tick = 0; ext_mask = 1;
    e = (tb_total / d) - (p0 / d);
    chk_rd("R5 time-base divide", 1, 32'(e));
    chk_rd("R5 time-base divide ctr4", 4, 32'(e));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    int exp;
    step(3);
    rst_n = 1;
    step(1);

    // R1 reset state
    chk_rd("R1 reset ctrl", 0, 0);
    for (int a = 1; a <= 4; a++) chk_rd("R1 reset counter", a, 0);
    chk_rd("R1 reset status", 5, 0);
    chk("R1 reset irq", 32'(irq), 0);

    // R2 cycle counting, several lengths
    foreach (pat[n]) if (n < 3) begin
      int len;
      len = (n == 0) ? 1 : (n == 1) ? 5 : 17;
      setup(cfg(1, 1, 1, 1, F_XMC), 0, 0, 0, 0);
      step(len);
      ext_mask = 1;
      for (int a = 1; a <= 4; a++) chk_rd("R2 cycle count", a, 32'(len));
    end

    // R3 completed instructions; R13 codes 0 and 6 never count
    pat = 32'hA5C3_0F17;
    setup(cfg(2, 2, 0, 6, F_XMC), 0, 0, 0, 0);
    for (int k = 0; k < 32; k++) begin ev_complete = pat[k]; step(1); end
    ev_complete = 0; ext_mask = 1;
    chk_rd("R3 completions", 1, 32'($countones(pat)));
    chk_rd("R3 completions ctr2", 2, 32'($countones(pat)));
    chk_rd("R13 code 0 idle", 3, 0);
    chk_rd("R13 code 6 idle", 4, 0);

    // R4 dispatch with clamp
    exp = 0;
    setup(cfg(3, 3, 3, 7, F_XMC), 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      ev_dispatch = 2'(k % 4);
      exp += ((k % 4) > 2) ? 2 : (k % 4);
      step(1);
    end
    ev_dispatch = 0; ext_mask = 1;
    chk_rd("R4 dispatch sum", 1, 32'(exp));
    chk_rd("R4 dispatch sum ctr3", 3, 32'(exp));
    chk_rd("R13 code 7 idle", 4, 0);

    // R5 time base prescale
    tb_run(0, 100, 1);
    tb_run(1, 8300, 1);
    tb_run(0, 90, 3);

    // R6 latency threshold sweep
    for (int sc = 0; sc < 2; sc++) begin
      for (int ti = 0; ti < 3; ti++) begin
        int thr, tv, cnt;
        int lv [6];
        thr = (ti == 0) ? 0 : (ti == 1) ? 3 : 63;
        tv = sc ? thr * 32 : thr * 2;
        lv = '{tv, tv + 1, tv + 5, (tv > 0) ? tv - 1 : 0, 0, 4095};
        cnt = 0;
        setup(cfg(5, 5, 5, 5, F_XMC | (sc ? F_SCALE : 0) | (32'(thr) << 10)), 0, 0, 0, 0);
        foreach (lv[j]) begin
          lat_valid = 1; lat_cycles = 12'(lv[j]);
          if (lv[j] > tv) cnt++;
          step(1);
        end
        lat_valid = 0; lat_cycles = 12'd4095; step(1);
        ext_mask = 1;
        chk_rd("R6 latency threshold", 1, 32'(cnt));
      end
    end

    // R7 freeze by privilege, mark, and global bit
    setup(cfg(1, 1, 1, 1, F_SUP), 0, 0, 0, 0);
    step(5); priv_user = 1; step(7);
    rd_addr = 1; #1; chk("R7 supervisor freeze", rd_data, 7);
    setup(cfg(1, 1, 1, 1, F_USR), 0, 0, 0, 0);
    priv_user = 1; step(4); priv_user = 0; step(6);
    rd_addr = 2; #1; chk("R7 user freeze", rd_data, 6);
    setup(cfg(1, 1, 1, 1, F_MARK | F_XMC), 0, 0, 0, 0);
    proc_mark = 1; step(3); proc_mark = 0; step(8); ext_mask = 1;
    chk_rd("R7 mark freeze", 3, 8);
    setup(cfg(1, 1, 1, 1, F_FRZ), 0, 0, 0, 0);
    step(10);
    chk_rd("R7 global freeze", 4, 0);

    // R10 external mask stops counting
    setup(cfg(1, 1, 1, 1, F_XMC), 0, 0, 0, 0);
    ext_mask = 1; step(5); ext_mask = 0; step(3); ext_mask = 1;
    chk_rd("R10 mask counting", 1, 3);

    // R8 chain; R9 counter 1 crossing gives no interrupt
    setup(cfg(1, 1, 1, 1, F_CHAIN | F_OIRQ | F_XMC), 32'h7FFF_FFFD, 0, 0, 0);
    step(10); ext_mask = 1;
    chk_rd("R8 chain head", 1, 32'h8000_0007);
    chk_rd("R8 chain tail", 2, 7);
    chk_rd("R8 chain tail ctr4", 4, 7);
    chk("R9 head crossing no irq", 32'(irq), 0);

    // R9 freeze and interrupt; R11 hold; R12 user writes dropped
    setup(cfg(1, 1, 1, 1, F_OFRZ | F_OIRQ), 0, 32'h7FFF_FFFE, 0, 0);
    step(6);
    chk_rd("R9 overflow freeze ctr1", 1, 2);
    chk_rd("R9 overflow freeze ctr2", 2, 32'h8000_0000);
    chk_rd("R9 freeze bit sticky", 0, cfg(1, 1, 1, 1, F_OFRZ | F_OIRQ | F_FRZ));
    chk("R9 irq raised", 32'(irq), 1);
    step(5);
    chk("R11 irq held", 32'(irq), 1);
    priv_user = 1;
    wr(5, 1); wr(1, 32'h1234);
    chk("R12 user clear ignored", 32'(irq), 1);
    chk_rd("R12 user counter write ignored", 1, 2);
    priv_user = 0;
    wr(5, 1);
    chk("R11 irq cleared", 32'(irq), 0);

    // R9 interrupt only: counting continues
    setup(cfg(1, 1, 1, 1, F_OIRQ | F_XMC), 0, 0, 0, 32'h7FFF_FFFF);
    step(4); ext_mask = 1;
    chk_rd("R9 irq-only keeps counting", 4, 32'h8000_0003);
    chk_rd("R9 irq-only no freeze", 0, cfg(1, 1, 1, 1, F_OIRQ | F_XMC));
    chk("R9 irq-only raised", 32'(irq), 1);

    // R10 mask blocks interrupt but not counting
    setup(cfg(1, 1, 1, 1, F_OIRQ | F_XMI), 0, 0, 32'h7FFF_FFFF, 0);
    ext_mask = 1; step(4);
    chk_rd("R10 masked irq counts", 3, 32'h8000_0003);
    chk("R10 irq suppressed", 32'(irq), 0);
    ext_mask = 0;
    wr(0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule